// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frame bytes from a MAC-side byte stream into memory buffers that a ring of descriptors describes. Software programs the ring base, pulses a software reset to place the descriptor pointer at that base, and then sets a single request bit. The engine reads the descriptor at the pointer. If the descriptor is owned by hardware, it accepts stream bytes into that descriptor's buffer. Once the buffer is full or the frame has ended, it writes the status back and advances along the ring. When it meets a descriptor that hardware does not own, it drops the request bit itself and parks.

Each descriptor takes 16 bytes. Word 0 carries the ownership flag in bit 31, the ring-wrap flag in bit 30, the frame-end flag in bit 29 (written by the engine) and free status bits in 28:0. Word 1 carries the buffer capacity in bits 31:16 and the stored byte count in bits 15:0. Word 2 is the word-aligned buffer address. Word 3 is unused.

If software drops the request bit while the engine is waiting for or taking frame bytes, the descriptor is abandoned without write-back. The engine then refuses to restart until a software reset.

Top module: `rx_desc_dma`

## Requirements
- R1: Register select 0 reads back as 31 zero bits above the request bit in bit 0, and a write there sets the request bit from bit 0 of the data. Select 1 is the ring base, and its bits 3:0 always read as zero.
- R2: After reset the request bit and ring base read 0, no memory access is issued and rx_ready_o is low.
- R3: With the request bit set and the engine idle, it reads descriptor words 0, 1 and 2 at the pointer. If word 0 bit 31 is 1, it then raises rx_ready_o.
- R4: If the fetched word 0 has bit 31 clear, the request bit is cleared by hardware, no memory write occurs and the engine stays idle.
- R5: Accepted bytes are packed little-endian, so byte k of a buffer lands at buffer address + k. Each 32-bit write enables only the lanes of bytes received, and bytes beyond the stored count stay untouched.
- R6: A buffer closes when its byte count reaches the capacity in word 1 bits 31:16, or when a byte with rx_last_i is taken. A frame longer than the capacity continues in the next descriptor.
- R7: Write-back clears bit 31 of word 0 and sets bit 29 if and only if the frame ended in this buffer, leaving bits 30 and 28:0 unchanged. Word 1 becomes {capacity, stored count}.
- R8: After write-back the pointer wraps to the ring base if word 0 bit 30 was set, and otherwise advances by 16. Fetching continues while the request bit is set.
- R9: Clearing the request bit while the engine waits for frame bytes abandons the descriptor with no write-back. Afterwards, setting the request bit starts no memory access.
- R10: A soft reset clears the request bit and the abandon condition, returns the engine to idle and loads the pointer from the ring base.
- R11: A memory request holds mem_valid_o with a stable address until mem_ready_i. Only one access is in flight at a time, and rx_ready_o is never high during a memory request.
- R12: A buffer of capacity 0 is written back with count 0 without accepting any byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Software reset pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 request, 1 ring base |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_ready_i | input | 1 | Memory accepts the request; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_last_i | input | 1 | Byte is the last of its frame |
| rx_ready_o | output | 1 | Engine takes the byte this cycle |

## Verification
The bench sweeps frame lengths from 1 to 10 across a two-descriptor ring with a capacity of 6. Lengths that are not multiples of four or that split across both buffers expose engines that write stray lanes, close a buffer one byte late, or set the frame-end flag on the first buffer of a split frame. Other cases cover an inactive first descriptor, a zero-capacity descriptor that wraps onto itself, and an abort on the second descriptor followed by a soft reset. A design that kept running after the abort, or resumed at the abandoned descriptor instead of the ring base, would put the next frame's byte into the wrong buffer. Memory ready stalls one cycle in three, which catches any request that moves its address before acceptance.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_RECV, S_STORE, S_WBACK, S_NEXT
  } st_e;
  localparam int unsigned OWN_BIT   = 31;
  localparam int unsigned WRAP_BIT  = 30;
  localparam int unsigned FEND_BIT  = 29;
  localparam int unsigned DESC_SPAN = 16;
endpackage

// File: rtl/rx_dma_regs.sv
module rx_dma_regs #(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              hw_clr_i,
  output logic              rr_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [DW-1:0]     rdata_o
);
  logic [ADDR_W-5:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rr_o <= 1'b0;
    else if (soft_rst_i)        rr_o <= 1'b0;
    else if (we_i && !sel_i)    rr_o <= wdata_i[0];
    else if (hw_clr_i)          rr_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             base_q <= '0;
    else if (we_i && sel_i)  base_q <= wdata_i[ADDR_W-1:4];
  end

  assign base_o  = {base_q, 4'b0000};
  assign rdata_o = sel_i ? DW'(base_o) : DW'(rr_o);
endmodule

// File: rtl/rx_dma_pack.sv
module rx_dma_pack #(
  parameter int unsigned LANES = 4,
  localparam int unsigned LW   = $clog2(LANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               put_i,
  input  logic [LW-1:0]      lane_i,
  input  logic [7:0]         byte_i,
  output logic [8*LANES-1:0] word_o,
  output logic [LANES-1:0]   be_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_o[8*l +: 8] <= '0;
        be_o[l]          <= 1'b0;
      end else if (clr_i) begin
        be_o[l] <= 1'b0;
      end else if (put_i && lane_i == LW'(l)) begin
        word_o[8*l +: 8] <= byte_i;
        be_o[l]          <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_dma_ctrl.sv
module rx_dma_ctrl
  import rx_dma_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LEN_W = DW / 2,
  localparam int unsigned LANES = DW / 8,
  localparam int unsigned LW    = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              rr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              hw_clr_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic [LANES-1:0]  mem_be_o,
  input  logic              mem_ready_i,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              rx_valid_i,
  input  logic              rx_last_i,
  output logic              rx_ready_o,
  output logic              put_o,
  output logic              clr_o,
  output logic [LW-1:0]     lane_o,
  input  logic [DW-1:0]     pk_word_i,
  input  logic [LANES-1:0]  pk_be_i,
  output st_e               state_o
);
  st_e               state;
  logic [ADDR_W-1:0] ptr, baddr, st_addr;
  logic [DW-1:0]     w0;
  logic [LEN_W-1:0]  blen, cnt;
  logic [1:0]        fidx;
  logic              widx, eof, poisoned;
  logic              take, close;
  logic [DW-1:0]     wb0;

  assign state_o     = state;
  assign rx_ready_o  = (state == S_RECV) && rr_i && (cnt != blen);
  assign take        = rx_ready_o && rx_valid_i;
  assign close       = rx_last_i || (cnt + LEN_W'(1) == blen) || (cnt[LW-1:0] == '1);
  assign put_o       = take;
  assign lane_o      = cnt[LW-1:0];
  assign clr_o       = (state == S_CHECK) || (state == S_STORE && mem_ready_i);
  assign hw_clr_o    = (state == S_CHECK) && !w0[OWN_BIT];
  assign mem_valid_o = (state == S_FETCH) || (state == S_STORE) || (state == S_WBACK);
  assign mem_we_o    = (state != S_FETCH);

  always_comb begin
    wb0           = w0;
    wb0[OWN_BIT]  = 1'b0;
    wb0[FEND_BIT] = eof;
  end

  always_comb begin
    mem_addr_o  = ptr;
    mem_wdata_o = wb0;
    mem_be_o    = '1;
    unique case (state)
      S_FETCH: mem_addr_o = ptr + ADDR_W'({fidx, 2'b00});
      S_STORE: begin
        mem_addr_o  = st_addr;
        mem_wdata_o = pk_word_i;
        mem_be_o    = pk_be_i;
      end
      S_WBACK: begin
        mem_addr_o  = ptr + ADDR_W'({widx, 2'b00});
        mem_wdata_o = widx ? {blen, cnt} : wb0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_IDLE; ptr <= '0; baddr <= '0; st_addr <= '0; w0 <= '0;
      blen <= '0; cnt <= '0; fidx <= '0; widx <= 1'b0; eof <= 1'b0; poisoned <= 1'b0;
    end else if (soft_rst_i) begin
      state <= S_IDLE; ptr <= base_i; poisoned <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (rr_i && !poisoned) begin
          state <= S_FETCH; fidx <= '0;
        end
        S_FETCH: if (mem_ready_i) begin
          unique case (fidx)
            2'd0:    w0    <= mem_rdata_i;
            2'd1:    blen  <= mem_rdata_i[DW-1:LEN_W];
            default: baddr <= mem_rdata_i[ADDR_W-1:0];
          endcase
          fidx <= fidx + 2'd1;
          if (fidx == 2'd2) state <= S_CHECK;
        end
        S_CHECK: begin
          cnt <= '0; eof <= 1'b0;
          state <= w0[OWN_BIT] ? S_RECV : S_IDLE;
        end
        S_RECV: begin
          if (!rr_i) begin
            state <= S_IDLE; poisoned <= 1'b1;   // write-back skipped
          end else if (take) begin
            cnt     <= cnt + LEN_W'(1);
            eof     <= rx_last_i;
            st_addr <= baddr + ADDR_W'({cnt[LEN_W-1:LW], {LW{1'b0}}});
            if (close) state <= S_STORE;
          end else if (cnt == blen) begin
            state <= S_WBACK; widx <= 1'b0;
          end
        end
        S_STORE: if (mem_ready_i) begin
          widx  <= 1'b0;
          state <= (eof || cnt == blen) ? S_WBACK : S_RECV;
        end
        S_WBACK: if (mem_ready_i) begin
          widx <= 1'b1;
          if (widx) state <= S_NEXT;
        end
        S_NEXT: begin
          ptr   <= w0[WRAP_BIT] ? base_i : ptr + ADDR_W'(DESC_SPAN);
          fidx  <= '0;
          state <= rr_i ? S_FETCH : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rx_dma_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LANES = DW / 8,
  localparam int unsigned LW    = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic [LANES-1:0]  mem_be_o,
  input  logic              mem_ready_i,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  output logic              rx_ready_o
);
  logic              rr, hw_clr, put, clr;
  logic [ADDR_W-1:0] base;
  logic [LW-1:0]     lane;
  logic [DW-1:0]     pk_word;
  logic [LANES-1:0]  pk_be;
  st_e               state;

  rx_dma_regs #(.DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .soft_rst_i,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .hw_clr_i(hw_clr), .rr_o(rr), .base_o(base), .rdata_o(reg_rdata_o)
  );

  rx_dma_pack #(.LANES(LANES)) u_pack (
    .clk_i, .rst_ni, .clr_i(clr), .put_i(put), .lane_i(lane),
    .byte_i(rx_data_i), .word_o(pk_word), .be_o(pk_be)
  );

  rx_dma_ctrl #(.DW(DW), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .soft_rst_i, .rr_i(rr), .base_i(base), .hw_clr_o(hw_clr),
    .mem_valid_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_be_o,
    .mem_ready_i, .mem_rdata_i, .rx_valid_i, .rx_last_i, .rx_ready_o,
    .put_o(put), .clr_o(clr), .lane_o(lane),
    .pk_word_i(pk_word), .pk_be_i(pk_be), .state_o(state)
  );
endmodule

// File: rtl/rx_dma_chk.sv
module rx_dma_chk
  import rx_dma_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              reg_we_i,
  input logic              reg_sel_i,
  input logic [DW-1:0]     reg_rdata_o,
  input logic              mem_valid_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DW-1:0]     mem_wdata_o,
  input logic              mem_ready_i,
  input logic              rx_ready_o,
  input st_e               state_i,
  input logic              rr_i
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> reg_rdata_o[DW-1:1] == '0);

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R11
  no_take_during_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> !mem_valid_o);

  // R4
  hw_clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rr_i) && !$past(reg_we_i) |-> state_i == S_IDLE);

  // R7
  own_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_WBACK && mem_valid_o && mem_addr_o[3:0] == 4'h0 |-> !mem_wdata_o[OWN_BIT]);

  // R10
  soft_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> state_i == S_IDLE && !rr_i && !mem_valid_o);
endmodule

bind rx_desc_dma rx_dma_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .reg_we_i(reg_we_i),
  .reg_sel_i(reg_sel_i), .reg_rdata_o(reg_rdata_o), .mem_valid_o(mem_valid_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .mem_ready_i(mem_ready_i), .rx_ready_o(rx_ready_o), .state_i(state), .rr_i(rr)
);

// File: tb/sim_rx_desc_dma.sv
module sim_rx_desc_dma;
  localparam time CLK_PERIOD = 10ns;
  localparam int  CAP = 6;

  logic        clk_i = 1'b0, rst_ni = 1'b0, soft_rst_i = 1'b0;
  logic        reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        mem_valid_o, mem_we_o, mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  mem_be_o;
  logic        rx_valid_i = 1'b0, rx_last_i = 1'b0, rx_ready_o;
  logic [7:0]  rx_data_i = '0;

  logic [31:0] mem [0:255];
  int checks = 0, fails = 0, rd_cnt = 0, wr_cnt = 0, viol = 0, cyc = 0, ph = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rx_desc_dma u0 (.*);

  assign mem_rdata_i = mem[mem_addr_o[9:2]];

  always @(negedge clk_i) begin
    ph          <= (ph == 2) ? 0 : ph + 1;
    mem_ready_i <= (ph != 1);
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (pend && (!mem_valid_o || mem_addr_o != pend_addr)) viol <= viol + 1;
    if (rx_ready_o && mem_valid_o) viol <= viol + 1;
    pend      <= mem_valid_o && !mem_ready_i;
    pend_addr <= mem_addr_o;
    if (mem_valid_o && mem_ready_i) begin
      if (mem_we_o) begin
        wr_cnt <= wr_cnt + 1;
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[mem_addr_o[9:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
      end else rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk_i) if (cyc > 100000) begin
    fails++;
    $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
    summary();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic sel, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic sel, output logic [31:0] d);
    reg_sel_i = sel; #1;
    d = reg_rdata_o;
  endtask

  task automatic soft_reset();
    @(negedge clk_i); soft_rst_i = 1'b1;
    @(negedge clk_i); soft_rst_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wait_ready(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk_i);
      seen = rx_ready_o;
    end
    chk(seen, tag, {31'b0, seen}, 32'h1);
  endtask

  task automatic wait_halt(input string tag);
    logic [31:0] d = 32'h1;
    for (int i = 0; i < 400 && d[0]; i++) begin
      @(negedge clk_i);
      reg_rd(1'b0, d);
    end
    chk(d == 32'h0, tag, d, 32'h0);
  endtask

  // bytes taken at the posedge following each negedge where rx_ready_o is high
  task automatic send(input int n, input int seed, input bit end_frame);
    for (int k = 0; k < n; k++) begin
      rx_valid_i = 1'b1;
      rx_data_i  = 8'(seed + k);
      rx_last_i  = end_frame && (k == n - 1);
      while (!rx_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    rx_valid_i = 1'b0; rx_last_i = 1'b0;
  endtask

  function automatic logic [7:0] mbyte(input int addr);
    return mem[addr[9:2]][8*addr[1:0] +: 8];
  endfunction

  task automatic init_ring(input logic [31:0] d0w0, input logic [31:0] d0cap);
    for (int i = 0; i < 4; i++) begin
      mem[8'h80 + i] = 32'hEEEE_EEEE;
      mem[8'h90 + i] = 32'hEEEE_EEEE;
    end
    mem[8'h40] = d0w0;          mem[8'h41] = d0cap << 16; mem[8'h42] = 32'h200; mem[8'h43] = '0;
    mem[8'h44] = 32'hC000_0007; mem[8'h45] = CAP << 16;   mem[8'h46] = 32'h240; mem[8'h47] = '0;
  endtask

  initial begin
    logic [31:0] d;
    int rd0, wr0, n0, n1;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: reset state
    reg_rd(1'b0, d); chk(d == 0, "R2 request after reset", d, 0);
    reg_rd(1'b1, d); chk(d == 0, "R2 base after reset", d, 0);
    chk(!mem_valid_o && !rx_ready_o, "R2 quiet after reset", {mem_valid_o, rx_ready_o}, 0);

    // R1: base low bits forced to zero
    reg_wr(1'b1, 32'h0000_010F);
    reg_rd(1'b1, d); chk(d == 32'h100, "R1 base alignment", d, 32'h100);

    // R5 R6 R7 R8: sweep frame lengths over a two-descriptor ring
    for (int len = 1; len <= 10; len++) begin
      soft_reset();
      init_ring(32'h8000_0005, CAP);
      reg_wr(1'b0, 32'h1);
      wait_ready("R3 ready on active descriptor");
      send(len, len * 16, 1'b1);
      n0 = (len < CAP) ? len : CAP;
      n1 = len - n0;
      if (n1 == 0) wait_ready("R8 advance to second descriptor");
      else         wait_halt("R8 wrap then halt on released descriptor");
      for (int k = 0; k < 8; k++)
        chk(mbyte(32'h200 + k) == ((k < n0) ? 8'(len * 16 + k) : 8'hEE),
            $sformatf("R5 buf0 byte %0d len %0d", k, len), mbyte(32'h200 + k),
            (k < n0) ? 8'(len * 16 + k) : 8'hEE);
      chk(mem[8'h40] == ((n1 == 0) ? 32'h2000_0005 : 32'h0000_0005),
          $sformatf("R7 desc0 status len %0d", len), mem[8'h40],
          (n1 == 0) ? 32'h2000_0005 : 32'h0000_0005);
      chk(mem[8'h41] == ((CAP << 16) | n0), $sformatf("R6 desc0 count len %0d", len),
          mem[8'h41], (CAP << 16) | n0);
      if (n1 != 0) begin
        for (int k = 0; k < 8; k++)
          chk(mbyte(32'h240 + k) == ((k < n1) ? 8'(len * 16 + CAP + k) : 8'hEE),
              $sformatf("R6 buf1 byte %0d len %0d", k, len), mbyte(32'h240 + k),
              (k < n1) ? 8'(len * 16 + CAP + k) : 8'hEE);
        chk(mem[8'h44] == 32'h6000_0007, "R7 desc1 status keeps wrap flag", mem[8'h44], 32'h6000_0007);
        chk(mem[8'h45] == ((CAP << 16) | n1), "R6 desc1 count", mem[8'h45], (CAP << 16) | n1);
      end else begin
        reg_wr(1'b0, 32'h0);   // abandon idle second descriptor; soft reset next pass
      end
    end

    // R3 R4 R1: inactive descriptor halts with no writes
    soft_reset();
    init_ring(32'h0000_0005, CAP);
    rd0 = rd_cnt; wr0 = wr_cnt;
    reg_wr(1'b0, 32'hFFFF_FFFF);
    reg_rd(1'b0, d); chk(d == 32'h1, "R1 request readback", d, 32'h1);
    idle(30);
    chk(rd_cnt - rd0 == 3, "R3 three descriptor reads", rd_cnt - rd0, 3);
    chk(wr_cnt == wr0, "R4 no write on inactive", wr_cnt - wr0, 0);
    reg_rd(1'b0, d); chk(d == 0, "R4 request cleared by hardware", d, 0);
    chk(!rx_ready_o, "R4 not ready after halt", rx_ready_o, 0);

    // R12: zero capacity wraps onto itself and halts
    soft_reset();
    init_ring(32'hC000_0009, 0);
    reg_wr(1'b0, 32'h1);
    wait_halt("R12 halt after zero-capacity buffer");
    chk(mem[8'h40] == 32'h4000_0009, "R12 status", mem[8'h40], 32'h4000_0009);
    chk(mem[8'h41] == 0, "R12 count zero", mem[8'h41], 0);
    chk(mem[8'h80] == 32'hEEEE_EEEE, "R12 buffer untouched", mem[8'h80], 32'hEEEE_EEEE);

    // R9 R10: abort on the second descriptor, then recover from the base
    soft_reset();
    init_ring(32'h8000_0005, CAP);
    reg_wr(1'b0, 32'h1);
    wait_ready("R9 setup ready");
    send(CAP, 8'h30, 1'b1);
    wait_ready("R9 second descriptor ready");
    send(2, 8'h50, 1'b0);
    reg_wr(1'b0, 32'h0);
    reg_wr(1'b0, 32'h1);
    rd0 = rd_cnt; wr0 = wr_cnt;
    idle(30);
    chk(rd_cnt == rd0 && wr_cnt == wr0, "R9 no access after abort", rd_cnt - rd0 + wr_cnt - wr0, 0);
    chk(!rx_ready_o, "R9 not ready after abort", rx_ready_o, 0);
    chk(mem[8'h44] == 32'hC000_0007, "R9 no write-back on abort", mem[8'h44], 32'hC000_0007);
    soft_reset();
    reg_rd(1'b0, d); chk(d == 0, "R10 soft reset clears request", d, 0);
    init_ring(32'h8000_0005, CAP);
    reg_wr(1'b0, 32'h1);
    wait_ready("R10 restart after soft reset");
    send(1, 8'hA7, 1'b1);
    wait_ready("R10 continues to next descriptor");
    chk(mbyte(32'h200) == 8'hA7, "R10 restart at ring base", mbyte(32'h200), 8'hA7);
    chk(mbyte(32'h240) == 8'hEE, "R10 abandoned buffer untouched", mbyte(32'h240), 8'hEE);
    chk(mem[8'h41] == ((CAP << 16) | 1), "R6 single byte count", mem[8'h41], (CAP << 16) | 1);

    // R11: handshake observed over the whole run
    chk(viol == 0, "R11 handshake violations", viol, 0);
    summary();
  end
endmodule